// File: doc/BRIEF.md
# Byte ALU with Carry, Half-Carry and Zero Flags

This block is the arithmetic and logic stage of a small accumulator-style processor core. Each operation combines the working register W with either a file-register operand f or an immediate literal k. It produces a byte result, a destination bit that tells the register-write logic whether the result goes to W or back to f, and new values for the Carry, Digit (half) Carry and Zero flags. Each flag has its own write enable, so each operation changes only the flags that belong to it.

The block is purely combinational. The core's decoder supplies a 5-bit operation code and the one-bit destination field from the instruction word. The core holds the status register and feeds the present carry back in, which add-with-carry, subtract-with-borrow and the rotates need. The data width is a parameter; the half-carry always comes from the boundary between the two halves of the word. A second parameter chooses between an explicit ripple carry chain and a plain behavioural adder.

Top module: `byte_alu_core`

## Requirements
- R1: Code 0 gives f+W and code 1 gives f+W+c_in. C is the carry out of bit 7 and DC is the carry out of bit 3. c_we, dc_we and z_we are all 1.
- R2: Code 2 gives f−W and code 3 gives f−W−(1−c_in). C is 1 when the full subtraction needs no borrow, and DC is 1 when the low-nibble subtraction needs no borrow. All three enables are 1.
- R3: Code 4 gives k+W and code 5 gives k−W. Flags follow R1 and R2 respectively, with all three enables set.
- R4: Codes 6, 7 and 8 give f AND W, f OR W and f XOR W. Codes 9, 10 and 11 apply the same operations to k and W. Only z_we is set.
- R5: Code 12 gives NOT f, code 13 gives f+1, code 14 gives f−1 and code 15 gives f. Only z_we is set, and an increment that wraps does not enable C.
- R6: Code 16 gives 0 with dest_f=1, and code 17 gives 0 with dest_f=0. Only z_we is set, and z_out is 1.
- R7: Code 18 gives W with dest_f=1, and code 19 gives k with dest_f=0. No flag enable is set.
- R8: Code 20 is an arithmetic right shift (bit 7 keeps its value), code 21 a logical left shift and code 22 a logical right shift (zero into bit 7). c_out is the bit shifted out. Only c_we and z_we are set.
- R9: Code 23 rotates f left and code 24 rotates f right, each through the carry: c_in enters at the vacated end and the bit leaving becomes c_out. Only c_we is set.
- R10: Code 25 exchanges the two nibbles of f and sets no flag enable.
- R11: dest_f equals dst_bit for codes 0–3, 6–8, 12–15 and 20–25. dest_f is 0 for codes 4, 5, 9–11, 17 and 19, and 1 for codes 16 and 18.
- R12: Any flag output whose enable is 0 reads 0. Codes 26–31 give result 0, dest_f 0 and no enables.
- R13: Whenever z_we is 1, z_out is 1 exactly when the 8-bit result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_in | input | DATA_W | Working register value |
| f_in | input | DATA_W | File-register operand |
| lit_in | input | DATA_W | Immediate literal from the instruction |
| op_sel | input | 5 | Operation code |
| dst_bit | input | 1 | Destination field of register-form instructions (1 = f) |
| c_in | input | 1 | Present carry flag |
| result | output | DATA_W | Operation result |
| dest_f | output | 1 | 1: write result to f, 0: write to W |
| c_out | output | 1 | New carry value |
| dc_out | output | 1 | New digit-carry value |
| z_out | output | 1 | New zero value |
| c_we | output | 1 | Carry write enable |
| dc_we | output | 1 | Digit-carry write enable |
| z_we | output | 1 | Zero write enable |

## Verification
The hardest cases to reach are the borrow chains of subtract-with-borrow: the incoming carry alone decides whether the result is zero with no borrow or all ones with a borrow in both nibbles. The half-carry has to be seen set while the full carry is clear, and the reverse. The stimulus table pins equal operands with both carry values, and operands such as 0x10−0x01 that borrow in the low nibble only. A sweep of operand pairs under both carry values then compares add-with-carry and subtract-with-borrow against a signed-arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD     = 5'd0,
      OP_ADDC    = 5'd1,
      OP_SUB     = 5'd2,
      OP_SUBB    = 5'd3,
      OP_ADDK    = 5'd4,
      OP_KSUB    = 5'd5,
      OP_AND     = 5'd6,
      OP_OR      = 5'd7,
      OP_XOR     = 5'd8,
      OP_ANDK    = 5'd9,
      OP_ORK     = 5'd10,
      OP_XORK    = 5'd11,
      OP_NOT     = 5'd12,
      OP_INC     = 5'd13,
      OP_DEC     = 5'd14,
      OP_PASS_F  = 5'd15,
      OP_CLR_F   = 5'd16,
      OP_CLR_W   = 5'd17,
      OP_STORE_W = 5'd18,
      OP_LOAD_K  = 5'd19,
      OP_SRA     = 5'd20,
      OP_SLL     = 5'd21,
      OP_SRL     = 5'd22,
      OP_ROL     = 5'd23,
      OP_ROR     = 5'd24,
      OP_SWAP    = 5'd25
   } alu_op_e;

   typedef enum logic [2:0] {
      U_ADDER, U_LOGIC, U_SHIFT, U_ZERO, U_PASS_W, U_PASS_K
   } unit_e;

   typedef enum logic [1:0] { B_W, B_NOT_W, B_ZERO, B_ONES } bsel_e;
   typedef enum logic [1:0] { CI_ZERO, CI_ONE, CI_FLAG }      cisel_e;
   typedef enum logic [1:0] { D_FIELD, D_W, D_F }             dsel_e;

   typedef struct packed {
      unit_e  unit;
      logic   a_lit;
      bsel_e  bsel;
      cisel_e cisel;
      dsel_e  dsel;
      logic   we_c;
      logic   we_dc;
      logic   we_z;
   } ctl_t;

   function automatic ctl_t decode_op(input logic [OP_W-1:0] code);
      ctl_t c;
      c = '{unit: U_ZERO, a_lit: 1'b0, bsel: B_W, cisel: CI_ZERO,
            dsel: D_W, we_c: 1'b0, we_dc: 1'b0, we_z: 1'b0};
      case (code)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
            c.unit  = U_ADDER;
            c.dsel  = D_FIELD;
            c.bsel  = (code == OP_ADD || code == OP_ADDC) ? B_W : B_NOT_W;
            c.cisel = (code == OP_ADD) ? CI_ZERO :
                      (code == OP_SUB) ? CI_ONE  : CI_FLAG;
            c.we_c = 1'b1; c.we_dc = 1'b1; c.we_z = 1'b1;
         end
         OP_ADDK, OP_KSUB: begin
            c.unit  = U_ADDER;
            c.a_lit = 1'b1;
            c.bsel  = (code == OP_ADDK) ? B_W : B_NOT_W;
            c.cisel = (code == OP_ADDK) ? CI_ZERO : CI_ONE;
            c.we_c = 1'b1; c.we_dc = 1'b1; c.we_z = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT, OP_PASS_F: begin
            c.unit = U_LOGIC;
            c.dsel = D_FIELD;
            c.we_z = 1'b1;
         end
         OP_ANDK, OP_ORK, OP_XORK: begin
            c.unit  = U_LOGIC;
            c.a_lit = 1'b1;
            c.we_z  = 1'b1;
         end
         OP_INC, OP_DEC: begin
            c.unit  = U_ADDER;
            c.dsel  = D_FIELD;
            c.bsel  = (code == OP_INC) ? B_ZERO : B_ONES;
            c.cisel = (code == OP_INC) ? CI_ONE : CI_ZERO;
            c.we_z  = 1'b1;
         end
         OP_CLR_F: begin c.dsel = D_F; c.we_z = 1'b1; end
         OP_CLR_W: begin c.dsel = D_W; c.we_z = 1'b1; end
         OP_STORE_W: begin c.unit = U_PASS_W; c.dsel = D_F; end
         OP_LOAD_K:  begin c.unit = U_PASS_K; c.dsel = D_W; end
         OP_SRA, OP_SLL, OP_SRL: begin
            c.unit = U_SHIFT;
            c.dsel = D_FIELD;
            c.we_c = 1'b1; c.we_z = 1'b1;
         end
         OP_ROL, OP_ROR: begin
            c.unit = U_SHIFT;
            c.dsel = D_FIELD;
            c.we_c = 1'b1;
         end
         OP_SWAP: begin c.unit = U_LOGIC; c.dsel = D_FIELD; end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
   import alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] w_in,
   input  bsel_e             bsel,
   input  cisel_e            cisel,
   input  logic              c_flag,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              hc_out
);
   localparam int NIB_W = DATA_W / 2;

   logic [DATA_W-1:0] b_opnd;
   logic              cin;

   always_comb begin
      case (bsel)
         B_W:     b_opnd = w_in;
         B_NOT_W: b_opnd = ~w_in;
         B_ONES:  b_opnd = '1;
         default: b_opnd = '0;
      endcase
      case (cisel)
         CI_ONE:  cin = 1'b1;
         CI_FLAG: cin = c_flag;
         default: cin = 1'b0;
      endcase
   end

   generate
      if (ADDER_STYLE == 0) begin : g_ripple
         logic [DATA_W:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = a_in[i] ^ b_opnd[i] ^ carry[i];
            assign carry[i+1] = (a_in[i] & b_opnd[i]) |
                                (carry[i] & (a_in[i] ^ b_opnd[i]));
         end
         assign c_out  = carry[DATA_W];
         assign hc_out = carry[NIB_W];

         // R1: the bit chain must agree with a word-wide addition
         logic [DATA_W:0] ref_sum;
         always_comb begin
            ref_sum = {1'b0, a_in} + {1'b0, b_opnd} + {{DATA_W{1'b0}}, cin};
            p_chain_matches_r1: assert ({c_out, sum} == ref_sum)
               else $error("ripple chain disagrees with word sum");
         end
      end else begin : g_behav
         logic [DATA_W:0] full;
         logic [NIB_W:0]  low;
         assign full   = {1'b0, a_in} + {1'b0, b_opnd} + {{DATA_W{1'b0}}, cin};
         assign low    = {1'b0, a_in[NIB_W-1:0]} + {1'b0, b_opnd[NIB_W-1:0]}
                         + {{NIB_W{1'b0}}, cin};
         assign sum    = full[DATA_W-1:0];
         assign c_out  = full[DATA_W];
         assign hc_out = low[NIB_W];
      end
   endgenerate

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] w_in,
   input  logic [OP_W-1:0]   code,
   output logic [DATA_W-1:0] res
);
   localparam int NIB_W = DATA_W / 2;

   always_comb begin
      case (code)
         OP_AND, OP_ANDK: res = a_in & w_in;
         OP_OR,  OP_ORK:  res = a_in | w_in;
         OP_XOR, OP_XORK: res = a_in ^ w_in;
         OP_NOT:          res = ~a_in;
         OP_SWAP:         res = {a_in[NIB_W-1:0], a_in[DATA_W-1:NIB_W]};
         default:         res = a_in;
      endcase
   end

   // R5: complement flips every bit of its operand
   always_comb begin
      if (code == OP_NOT) begin
         p_not_flips_all_r5: assert ((res ^ a_in) == {DATA_W{1'b1}})
            else $error("complement left a bit unflipped");
      end
   end

   // R10: a nibble swap keeps the number of set bits
   always_comb begin
      if (code == OP_SWAP) begin
         p_swap_keeps_bits_r10: assert ($countones(res) == $countones(a_in))
            else $error("nibble swap changed bit count");
      end
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] f_in,
   input  logic              c_flag,
   input  logic [OP_W-1:0]   code,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);
   always_comb begin
      case (code)
         OP_SRA: begin
            res   = {f_in[DATA_W-1], f_in[DATA_W-1:1]};
            c_out = f_in[0];
         end
         OP_SLL: begin
            res   = {f_in[DATA_W-2:0], 1'b0};
            c_out = f_in[DATA_W-1];
         end
         OP_SRL: begin
            res   = {1'b0, f_in[DATA_W-1:1]};
            c_out = f_in[0];
         end
         OP_ROL: begin
            res   = {f_in[DATA_W-2:0], c_flag};
            c_out = f_in[DATA_W-1];
         end
         OP_ROR: begin
            res   = {c_flag, f_in[DATA_W-1:1]};
            c_out = f_in[0];
         end
         default: begin
            res   = f_in;
            c_out = c_flag;
         end
      endcase
   end

   // R9: a rotate through carry neither creates nor loses a set bit
   always_comb begin
      if (code == OP_ROL || code == OP_ROR) begin
         p_rotate_conserves_r9: assert ($countones({c_out, res}) ==
                                        $countones({c_flag, f_in}))
            else $error("rotate through carry changed bit count");
      end
   end

   // R8: the logical left shift drops bit 7 into carry and zero-fills
   always_comb begin
      if (code == OP_SLL) begin
         p_sll_shape_r8: assert ({c_out, res} == {f_in, 1'b0})
            else $error("left shift produced wrong shape");
      end
   end

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
   import alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] w_in,
   input  logic [DATA_W-1:0] f_in,
   input  logic [DATA_W-1:0] lit_in,
   input  logic [4:0]        op_sel,
   input  logic              dst_bit,
   input  logic              c_in,
   output logic [DATA_W-1:0] result,
   output logic              dest_f,
   output logic              c_out,
   output logic              dc_out,
   output logic              z_out,
   output logic              c_we,
   output logic              dc_we,
   output logic              z_we
);
   localparam int NIB_W = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 4");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("ADDER_STYLE must be 0 (ripple) or 1 (behavioural)");
      end
   endgenerate

   ctl_t              ctl;
   logic [DATA_W-1:0] a_opnd;
   logic [DATA_W-1:0] add_res, log_res, sh_res;
   logic              add_c, add_hc, sh_c;

   assign ctl    = decode_op(op_sel);
   assign a_opnd = ctl.a_lit ? lit_in : f_in;

   alu_addsub #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_addsub (
      .a_in   (a_opnd),
      .w_in   (w_in),
      .bsel   (ctl.bsel),
      .cisel  (ctl.cisel),
      .c_flag (c_in),
      .sum    (add_res),
      .c_out  (add_c),
      .hc_out (add_hc)
   );

   alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_in (a_opnd),
      .w_in (w_in),
      .code (op_sel),
      .res  (log_res)
   );

   alu_shift #(.DATA_W(DATA_W)) u_shift (
      .f_in   (f_in),
      .c_flag (c_in),
      .code   (op_sel),
      .res    (sh_res),
      .c_out  (sh_c)
   );

   always_comb begin
      case (ctl.unit)
         U_ADDER:  result = add_res;
         U_LOGIC:  result = log_res;
         U_SHIFT:  result = sh_res;
         U_PASS_W: result = w_in;
         U_PASS_K: result = lit_in;
         default:  result = '0;
      endcase
      case (ctl.dsel)
         D_FIELD: dest_f = dst_bit;
         D_F:     dest_f = 1'b1;
         default: dest_f = 1'b0;
      endcase
      c_we   = ctl.we_c;
      dc_we  = ctl.we_dc;
      z_we   = ctl.we_z;
      c_out  = ctl.we_c  & ((ctl.unit == U_SHIFT) ? sh_c : add_c);
      dc_out = ctl.we_dc & add_hc;
      z_out  = ctl.we_z  & ~|result;
   end

   // R12: undefined codes produce nothing and touch no flag
   always_comb begin
      if (op_sel > 5'd25) begin
         p_undef_quiet_r12: assert (result == '0 && !c_we && !dc_we && !z_we
                                    && !dest_f)
            else $error("undefined code had an effect");
      end
   end

   // R11: literal-form operations always return to W
   always_comb begin
      if (op_sel inside {OP_ADDK, OP_KSUB, OP_ANDK, OP_ORK, OP_XORK,
                         OP_LOAD_K, OP_CLR_W}) begin
         p_literal_to_w_r11: assert (!dest_f)
            else $error("literal-form result sent to f");
      end
   end

   // R10: swap sets no flag enable and places f's low nibble on top
   always_comb begin
      if (op_sel == OP_SWAP) begin
         p_swap_silent_r10: assert (!c_we && !dc_we && !z_we &&
                                    result[DATA_W-1:NIB_W] == f_in[NIB_W-1:0])
            else $error("nibble swap wrong or touched a flag");
      end
   end

   // R6: a clear always reports zero
   always_comb begin
      if (op_sel == OP_CLR_F || op_sel == OP_CLR_W) begin
         p_clear_sets_z_r6: assert (z_we && z_out && !c_we && !dc_we)
            else $error("clear did not report zero correctly");
      end
   end

endmodule

// File: tb/test_byte_alu_core.sv
module test_byte_alu_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] w_in = '0, f_in = '0, lit_in = '0;
   logic [4:0] op_sel = '0;
   logic       dst_bit = 1'b0, c_in = 1'b0;
   logic [7:0] result;
   logic       dest_f, c_out, dc_out, z_out, c_we, dc_we, z_we;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   byte_alu_core i_byte_alu_core (
      .w_in(w_in), .f_in(f_in), .lit_in(lit_in), .op_sel(op_sel),
      .dst_bit(dst_bit), .c_in(c_in), .result(result), .dest_f(dest_f),
      .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
      .c_we(c_we), .dc_we(dc_we), .z_we(z_we)
   );

   typedef struct packed {
      logic [4:0] op;
      logic [7:0] w;
      logic [7:0] f;
      logic [7:0] k;
      logic       d;
      logic       ci;
      logic [7:0] res;
      logic       dst;
      logic       c;
      logic       dc;
      logic       z;
      logic [2:0] we;   // {c_we, dc_we, z_we}
   } vec_t;

   localparam int NV = 36;
   localparam vec_t TBL [NV] = '{
      '{5'd0,  8'h0F, 8'h01, 8'h00, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111},
      '{5'd0,  8'h80, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'b111},
      '{5'd1,  8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 3'b111},
      '{5'd1,  8'h12, 8'h34, 8'h00, 1'b0, 1'b0, 8'h46, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111},
      '{5'd2,  8'h03, 8'h05, 8'h00, 1'b1, 1'b0, 8'h02, 1'b1, 1'b1, 1'b1, 1'b0, 3'b111},
      '{5'd2,  8'h05, 8'h03, 8'h00, 1'b0, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111},
      '{5'd2,  8'h01, 8'h10, 8'h00, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111},
      '{5'd3,  8'h10, 8'h10, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111},
      '{5'd3,  8'h10, 8'h10, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111},
      '{5'd4,  8'h08, 8'hAA, 8'h08, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111},
      '{5'd5,  8'h01, 8'h55, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111},
      '{5'd6,  8'h0F, 8'hF0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd7,  8'h05, 8'hA0, 8'h00, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001},
      '{5'd8,  8'h5A, 8'h5A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd9,  8'hF0, 8'h00, 8'h3C, 1'b1, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001},
      '{5'd10, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd11, 8'h0F, 8'h00, 8'hFF, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001},
      '{5'd12, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd13, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd14, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd14, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001},
      '{5'd15, 8'h12, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd16, 8'h33, 8'h77, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd17, 8'h33, 8'h77, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
      '{5'd18, 8'h00, 8'h55, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000},
      '{5'd19, 8'h11, 8'h22, 8'h9C, 1'b1, 1'b0, 8'h9C, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000},
      '{5'd20, 8'h00, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101},
      '{5'd21, 8'h00, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'b101},
      '{5'd22, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 3'b101},
      '{5'd22, 8'h00, 8'h82, 8'h00, 1'b0, 1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101},
      '{5'd23, 8'h00, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100},
      '{5'd24, 8'h00, 8'h01, 8'h00, 1'b1, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 3'b100},
      '{5'd24, 8'h00, 8'h02, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100},
      '{5'd25, 8'h00, 8'hA5, 8'h00, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000},
      '{5'd26, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000},
      '{5'd31, 8'h01, 8'h02, 8'h03, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000}
   };

   function automatic string op_req(input logic [4:0] op);
      case (op)
         5'd0, 5'd1:                   return "R1";
         5'd2, 5'd3:                   return "R2";
         5'd4, 5'd5:                   return "R3";
         5'd6, 5'd7, 5'd8,
         5'd9, 5'd10, 5'd11:           return "R4";
         5'd12, 5'd13, 5'd14, 5'd15:   return "R5";
         5'd16, 5'd17:                 return "R6";
         5'd18, 5'd19:                 return "R7";
         5'd20, 5'd21, 5'd22:          return "R8";
         5'd23, 5'd24:                 return "R9";
         5'd25:                        return "R10";
         default:                      return "R12";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [4:0] op, input logic [7:0] w,
                        input logic [7:0] f, input logic [7:0] k,
                        input logic d, input logic ci);
      @(posedge clk);
      op_sel = op; w_in = w; f_in = f; lit_in = k; dst_bit = d; c_in = ci;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // idle state: code 0 with all-zero operands, R1 and R13
      @(negedge clk);
      check("R1",  "idle result", int'(result), 0);
      check("R13", "idle z",      int'(z_out),  1);
      check("R1",  "idle we",     int'({c_we, dc_we, z_we}), 3'b111);

      // table walk
      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = op_req(TBL[i].op);
         apply(TBL[i].op, TBL[i].w, TBL[i].f, TBL[i].k, TBL[i].d, TBL[i].ci);
         check(rq,    $sformatf("v%0d result", i), int'(result), int'(TBL[i].res));
         check("R11", $sformatf("v%0d dest", i),   int'(dest_f), int'(TBL[i].dst));
         check(rq,    $sformatf("v%0d we", i),     int'({c_we, dc_we, z_we}),
               int'(TBL[i].we));
         check(TBL[i].we[2] ? rq : "R12", $sformatf("v%0d c", i),
               int'(c_out), int'(TBL[i].c));
         check(TBL[i].we[1] ? rq : "R12", $sformatf("v%0d dc", i),
               int'(dc_out), int'(TBL[i].dc));
         check(TBL[i].we[0] ? "R13" : "R12", $sformatf("v%0d z", i),
               int'(z_out), int'(TBL[i].z));
      end

      // directed: destination field follows dst_bit on register forms, R11
      for (int d = 0; d < 2; d++) begin
         apply(5'd6, 8'hFF, 8'h0F, 8'h00, d[0], 1'b0);
         check("R11", "AND dest follows field", int'(dest_f), d);
         apply(5'd20, 8'h00, 8'h02, 8'h00, d[0], 1'b1);
         check("R11", "SRA dest follows field", int'(dest_f), d);
      end

      // directed: rotate left inserts carry at bit 0, R9
      apply(5'd23, 8'h00, 8'h40, 8'h00, 1'b0, 1'b1);
      check("R9", "ROL carry in", int'(result), 8'h81);
      check("R9", "ROL carry out", int'(c_out), 0);

      // directed: increment wrap does not enable carry, R5
      apply(5'd13, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
      check("R5", "INC wrap c_we", int'(c_we), 0);

      // directed: arithmetic right shift of a negative value keeps sign, R8
      apply(5'd20, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
      check("R8", "SRA sign fill", int'(result), 8'hFF);
      check("R8", "SRA carry", int'(c_out), 1);

      // sweep: add-with-carry and subtract-with-borrow against a model, R1 R2
      for (int wv = 0; wv < 256; wv += 17) begin
         for (int fv = 0; fv < 256; fv += 23) begin
            for (int ci = 0; ci < 2; ci++) begin
               int s, lo, diff, dlo;
               s  = fv + wv + ci;
               lo = (fv % 16) + (wv % 16) + ci;
               apply(5'd1, 8'(wv), 8'(fv), 8'h00, 1'b0, ci[0]);
               check("R1", "ADDC result", int'(result), s % 256);
               check("R1", "ADDC c",      int'(c_out),  (s > 255) ? 1 : 0);
               check("R1", "ADDC dc",     int'(dc_out), (lo > 15) ? 1 : 0);
               check("R13", "ADDC z",     int'(z_out),  ((s % 256) == 0) ? 1 : 0);
               diff = fv - wv - (1 - ci);
               dlo  = (fv % 16) - (wv % 16) - (1 - ci);
               apply(5'd3, 8'(wv), 8'(fv), 8'h00, 1'b1, ci[0]);
               check("R2", "SUBB result", int'(result), (diff + 256) % 256);
               check("R2", "SUBB c",      int'(c_out),  (diff >= 0) ? 1 : 0);
               check("R2", "SUBB dc",     int'(dc_out), (dlo >= 0) ? 1 : 0);
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule